// File: doc/BRIEF.md
# Registered Bidirectional Barrel Shifter

This block moves a 16-bit word left or right by any distance from 0 to 15 bit positions in a single pass. On each rising clock edge it registers the data word, the 4-bit distance, a direction select and a signedness select. The shifted result is then formed from those registered values. The output therefore follows the inputs by one clock.

Left moves always bring zeros into the low end. Right moves bring either zeros into the high end (unsigned) or copies of the registered top bit (signed, two's complement). The choice is made by the signedness select.

A parameter can add a register on the result, which gives two clocks of latency. The datapath is a four-level logarithmic network of 1-, 2-, 4- and 8-position steps. Each step is enabled by the matching bit of the distance.

Top module: `bishift_reg`

## Requirements
- R1: `dout` depends only on the values of `din`, `amt`, `dir_right` and `arith` sampled at a rising clock edge. An input change between edges has no effect on `dout` until the next edge.
- R2: With `dir_right` = 0, `dout` is the sampled word moved toward the MSB by `amt` positions, with zeros in the vacated low bits, whatever the value of `arith`.
- R3: With `dir_right` = 1 and `arith` = 0, `dout` is the sampled word moved toward the LSB by `amt` positions, with zeros in the vacated high bits.
- R4: With `dir_right` = 1 and `arith` = 1, `dout` is the sampled word moved toward the LSB by `amt` positions. Every vacated high bit equals bit 15 of the sampled word.
- R5: With `amt` = 0, `dout` equals the sampled word in both directions and both signedness settings.
- R6: Every distance from 0 to 15 is supported. At distance 15, only one bit of the sampled word survives.
- R7: `rst` is active high and synchronous. At a rising edge where `rst` = 1, all internal registers clear, so `dout` reads 0 afterwards. `rst` has no effect between edges.
- R8: With `OUT_REG` = 0, `dout` reflects the inputs sampled at the most recent edge. With `OUT_REG` = 1, `dout` reflects the inputs sampled one edge earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 16 | Data word to shift |
| amt | input | 4 | Shift distance, 0 to 15 |
| dir_right | input | 1 | 1: move toward LSB, 0: move toward MSB |
| arith | input | 1 | 1: signed word (sign fill on right moves), 0: unsigned |
| dout | output | 16 | Shifted word |

## Verification
Four corner words are applied at every distance, in both directions and both signedness settings. The word 0x8000 separates sign fill from zero fill, and 0x7FFF shows that a clear top bit gives zero fill even in signed mode. The word 0xFFFF exposes the exact fill width on left moves, and 0x0001 reveals a distance misdecoded by one step. Seeded random words and settings then cover mixed bit patterns. Directed sequences check that a mid-cycle input change and a between-edge reset leave the output alone, and a second instance with the output register confirms the extra cycle.

// File: rtl/bishift_reg.sv
module bishift_reg #(
  parameter int W       = 16,
  parameter int OUT_REG = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [W-1:0]         din,
  input  logic [$clog2(W)-1:0] amt,
  input  logic                 dir_right,
  input  logic                 arith,
  output logic [W-1:0]         dout
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  cap_din;
  logic [CW-1:0] cap_amt;
  logic          cap_right;
  logic          cap_arith;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_din   <= '0;
      cap_amt   <= '0;
      cap_right <= 1'b0;
      cap_arith <= 1'b0;
    end else begin
      cap_din   <= din;
      cap_amt   <= amt;
      cap_right <= dir_right;
      cap_arith <= arith;
    end
  end

  function automatic logic [W-1:0] flip(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  logic [CW:0][W-1:0] stg;
  logic               fill;
  logic [W-1:0]       result;

  assign fill   = cap_right & cap_arith & cap_din[W-1];
  assign stg[0] = cap_right ? cap_din : flip(cap_din);

  for (genvar s = 0; s < CW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stg[s+1] = cap_amt[s] ? {{STEP{fill}}, stg[s][W-1:STEP]} : stg[s];
  end

  assign result = cap_right ? stg[CW] : flip(stg[CW]);

  if (OUT_REG != 0) begin : g_oreg
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= result;
    end
    assign dout = q;
  end else begin : g_comb
    assign dout = result;
  end
endmodule

module bishift_reg_chk #(
  parameter int W       = 16,
  parameter int OUT_REG = 0
) (
  input logic                 clk,
  input logic                 rst,
  input logic [W-1:0]         din,
  input logic [$clog2(W)-1:0] amt,
  input logic                 dir_right,
  input logic                 arith,
  input logic [W-1:0]         dout
);
  // R7
  rst_clears_chk: assert property (@(posedge clk) rst |=> dout == '0);

  if (OUT_REG == 0) begin : g_lat1
    // R5
    zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (amt == '0) |=> dout == $past(din));
    // R2
    left_lsb_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (!dir_right && amt != '0) |=> dout[0] == 1'b0);
    // R3
    lright_msb_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (dir_right && !arith && amt != '0) |=> dout[W-1] == 1'b0);
    // R4
    aright_sign_chk: assert property (@(posedge clk) disable iff (rst)
      (dir_right && arith) |=> dout[W-1] == $past(din[W-1]));
  end
endmodule

bind bishift_reg bishift_reg_chk #(.W(W), .OUT_REG(OUT_REG)) chk_i (
  .clk(clk), .rst(rst), .din(din), .amt(amt),
  .dir_right(dir_right), .arith(arith), .dout(dout)
);

// File: tb/bishift_reg_tb_top.sv
module bishift_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] din = '0;
  logic [3:0]  amt = '0;
  logic        dir_right = 1'b0;
  logic        arith = 1'b0;
  logic [15:0] dout, dout2;
  logic [15:0] exp_prev = '0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  bishift_reg #(.W(16), .OUT_REG(0)) dut_i (
    .clk(clk), .rst(rst), .din(din), .amt(amt),
    .dir_right(dir_right), .arith(arith), .dout(dout));

  bishift_reg #(.W(16), .OUT_REG(1)) dut_lat2_i (
    .clk(clk), .rst(rst), .din(din), .amt(amt),
    .dir_right(dir_right), .arith(arith), .dout(dout2));

  function automatic logic [15:0] model(logic [15:0] d, logic [3:0] a, logic r, logic s);
    if (!r) return d << a;
    if (s)  return 16'($signed(d) >>> a);
    return d >> a;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag(logic [3:0] a, logic r, logic s);
    if (a == 0) return "R5";
    if (a == 15) return "R6";
    if (!r) return "R2";
    return s ? "R4" : "R3";
  endfunction

  // drive at negedge, check at the following negedge
  task automatic apply(logic [15:0] d, logic [3:0] a, logic r, logic s);
    logic [15:0] e;
    din = d; amt = a; dir_right = r; arith = s;
    e = model(d, a, r, s);
    @(negedge clk);
    check(tag(a, r, s), dout, e);
    check("R8", dout2, exp_prev);
    exp_prev = e;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] corners [4];
    void'($urandom(32'd1234));
    corners[0] = 16'h8000; corners[1] = 16'h7FFF;
    corners[2] = 16'hFFFF; corners[3] = 16'h0001;

    @(negedge clk); @(negedge clk);
    check("R7", dout, 16'h0000);
    check("R7", dout2, 16'h0000);
    rst = 1'b0;

    for (int c = 0; c < 4; c++)
      for (int a = 0; a < 16; a++)
        for (int m = 0; m < 4; m++)
          apply(corners[c], 4'(a), m[1], m[0]);

    for (int k = 0; k < 2000; k++)
      apply(16'($urandom), 4'($urandom), 1'($urandom), 1'($urandom));

    // R1: mid-cycle change does not disturb output
    din = 16'hA5C3; amt = 4'd4; dir_right = 1'b1; arith = 1'b1;
    @(posedge clk); #1;
    din = 16'h0F0F; amt = 4'd1; dir_right = 1'b0; arith = 1'b0;
    @(negedge clk);
    check("R1", dout, 16'hFA5C);
    @(negedge clk);
    check("R1", dout, 16'h1E1E);

    // R7: reset acts only at an edge
    rst = 1'b1;
    #1;
    check("R7", dout, 16'h1E1E);
    @(negedge clk);
    check("R7", dout, 16'h0000);
    check("R7", dout2, 16'h0000);
    rst = 1'b0;
    exp_prev = 16'h0000;
    apply(16'h0001, 4'd15, 1'b0, 1'b1);
    apply(16'h8000, 4'd15, 1'b1, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule